// File: doc/BRIEF.md
# Next-PC Resolver for Conditional Flow

This block works out the program counter that follows the current instruction in a small in-order core, together with the number of cycles that instruction occupies. It covers conditional branches that test any one bit of the status byte for set or clear, relative jumps, relative calls, and skip tests that step over a following instruction that is either one or two words long. Fetch, decode and the return stack live elsewhere. The decoder supplies the operation kind, the operands and the condition inputs, and it raises a strobe while they are valid.

The result is registered. One clock edge after the strobe, the new PC and the cycle count appear at the outputs, and a result-valid pulse marks them for one cycle. The outputs hold their values until the next strobe. All PC arithmetic wraps modulo 2^PC_W.

Top module: `flow_resolver`

## Requirements
- R1: For a conditional branch (opKind 1) whose condition holds, nextPc = pcIn + k + 1, where k is the 7-bit `brOffset` read as signed and sign-extended. If the condition does not hold, nextPc = pcIn + 1.
- R2: A conditional branch reports cyclesOut = 2 when taken and 1 when not taken.
- R3: The branch condition is `status[bitSel] == polarity`. Any of the eight status bit positions 0..7 can be tested, and polarity 1 means branch if the bit is set, 0 means branch if it is clear.
- R4: A relative jump (opKind 2) gives nextPc = pcIn + j + 1, where j is the 12-bit `jmpOffset` read as signed, and cyclesOut = 2.
- R5: A relative call (opKind 3) gives the same target as a jump and cyclesOut = 3.
- R6: A skip (opKind 4) with `skipCond` high gives nextPc = pcIn + 2 and cyclesOut = 2 when `nextIsLong` is 0, or nextPc = pcIn + 3 and cyclesOut = 3 when it is 1.
- R7: A skip with `skipCond` low gives nextPc = pcIn + 1 and cyclesOut = 1, whatever `nextIsLong` is.
- R8: A plain instruction (opKind 0, and the unused codes 5..7) gives nextPc = pcIn + 1 and cyclesOut = 1.
- R9: All PC sums wrap modulo 2^PC_W, both forward past the top and backward past zero.
- R10: Results appear at the first rising edge after `instValid` is sampled high, with `resValid` high for exactly that cycle. While `instValid` is low, nextPc and cyclesOut hold and all other inputs are ignored.
- R11: While `rstN` is low, nextPc, cyclesOut and resValid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Operands are valid this cycle |
| opKind | input | 3 | 0 plain, 1 branch, 2 jump, 3 call, 4 skip |
| pcIn | input | PC_W | Address of the current instruction |
| brOffset | input | BR_OFF_W | Signed branch offset in words |
| jmpOffset | input | JMP_OFF_W | Signed jump/call offset in words |
| status | input | 8 | Status byte |
| bitSel | input | 3 | Status bit to test |
| polarity | input | 1 | Required value of the tested bit |
| skipCond | input | 1 | Skip test result |
| nextIsLong | input | 1 | The following instruction is two words long |
| nextPc | output | PC_W | Resolved next PC |
| cyclesOut | output | 2 | Cycles taken by the instruction |
| resValid | output | 1 | New result this cycle |

## Verification
The control decode is purely combinational, and one output register follows it, so every result is due exactly one rising edge after the strobe is sampled. The bench drives the inputs on the falling edge, waits one full period, and samples on the next falling edge, where the registered values are stable. Holding behaviour is checked one cycle later with the strobe low and the inputs scrambled.

// File: rtl/flow_resolver_pkg.sv
package flow_resolver_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN  = 3'd0,
    OP_BRANCH = 3'd1,
    OP_JUMP   = 3'd2,
    OP_CALL   = 3'd3,
    OP_SKIP   = 3'd4
  } opKind_e;

  typedef enum logic [2:0] {
    ADD_ONE   = 3'd0,
    ADD_TWO   = 3'd1,
    ADD_THREE = 3'd2,
    ADD_BR    = 3'd3,
    ADD_JMP   = 3'd4
  } addSel_e;

  typedef struct packed {
    addSel_e    addSel;
    logic [1:0] cycles;
    logic       load;
  } ctrlStrobe_t;
endpackage

// File: rtl/flow_resolver_ctrl.sv
module flow_resolver_ctrl
  import flow_resolver_pkg::*;
(
  input  logic        instValid,
  input  logic [2:0]  opKind,
  input  logic [7:0]  status,
  input  logic [2:0]  bitSel,
  input  logic        polarity,
  input  logic        skipCond,
  input  logic        nextIsLong,
  output ctrlStrobe_t stb
);
  logic condMet;

  assign condMet = (status[bitSel] == polarity);

  always_comb begin
    stb.load   = instValid;
    stb.addSel = ADD_ONE;
    stb.cycles = 2'd1;
    case (opKind)
      OP_BRANCH: begin
        if (condMet) begin
          stb.addSel = ADD_BR;
          stb.cycles = 2'd2;
        end
      end
      OP_JUMP: begin
        stb.addSel = ADD_JMP;
        stb.cycles = 2'd2;
      end
      OP_CALL: begin
        stb.addSel = ADD_JMP;
        stb.cycles = 2'd3;
      end
      OP_SKIP: begin
        if (skipCond) begin
          stb.addSel = nextIsLong ? ADD_THREE : ADD_TWO;
          stb.cycles = nextIsLong ? 2'd3 : 2'd2;
        end
      end
      default: ;
    endcase
  end

  // R2 R6: a non-sequential step never reports a single cycle
  always_comb begin
    if (instValid && stb.addSel != ADD_ONE)
      a_r2_multi_cycle: assert (stb.cycles != 2'd1);
    if (instValid)
      a_r6_cycles_nonzero: assert (stb.cycles != 2'd0);
  end
endmodule

// File: rtl/flow_resolver_dp.sv
module flow_resolver_dp
  import flow_resolver_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int BR_OFF_W  = 7,
  parameter int JMP_OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          stb,
  input  logic [PC_W-1:0]      pcIn,
  input  logic [BR_OFF_W-1:0]  brOffset,
  input  logic [JMP_OFF_W-1:0] jmpOffset,
  output logic [PC_W-1:0]      nextPc,
  output logic [1:0]           cyclesOut,
  output logic                 resValid
);
  localparam int BR_PAD  = PC_W - BR_OFF_W;
  localparam int JMP_PAD = PC_W - JMP_OFF_W;

  logic [PC_W-1:0] brExt;
  logic [PC_W-1:0] jmpExt;
  logic [PC_W-1:0] addend;
  logic [PC_W-1:0] sum;

  assign brExt  = {{BR_PAD{brOffset[BR_OFF_W-1]}}, brOffset};
  assign jmpExt = {{JMP_PAD{jmpOffset[JMP_OFF_W-1]}}, jmpOffset};

  always_comb begin
    case (stb.addSel)
      ADD_TWO:   addend = PC_W'(2);
      ADD_THREE: addend = PC_W'(3);
      ADD_BR:    addend = brExt + PC_W'(1);
      ADD_JMP:   addend = jmpExt + PC_W'(1);
      default:   addend = PC_W'(1);
    endcase
    sum = pcIn + addend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc    <= '0;
      cyclesOut <= '0;
      resValid  <= 1'b0;
    end else begin
      resValid <= stb.load;
      if (stb.load) begin
        nextPc    <= sum;
        cyclesOut <= stb.cycles;
      end
    end
  end

  // R10: outputs hold while no instruction is presented
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(nextPc) && $stable(cyclesOut)));
  // R10: result-valid follows the load strobe by one edge
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> resValid);
endmodule

// File: rtl/flow_resolver.sv
module flow_resolver
  import flow_resolver_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int BR_OFF_W  = 7,
  parameter int JMP_OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic [2:0]           opKind,
  input  logic [PC_W-1:0]      pcIn,
  input  logic [BR_OFF_W-1:0]  brOffset,
  input  logic [JMP_OFF_W-1:0] jmpOffset,
  input  logic [7:0]           status,
  input  logic [2:0]           bitSel,
  input  logic                 polarity,
  input  logic                 skipCond,
  input  logic                 nextIsLong,
  output logic [PC_W-1:0]      nextPc,
  output logic [1:0]           cyclesOut,
  output logic                 resValid
);
  ctrlStrobe_t stb;

  flow_resolver_ctrl u_ctrl (
    .instValid (instValid),
    .opKind    (opKind),
    .status    (status),
    .bitSel    (bitSel),
    .polarity  (polarity),
    .skipCond  (skipCond),
    .nextIsLong(nextIsLong),
    .stb       (stb)
  );

  flow_resolver_dp #(
    .PC_W     (PC_W),
    .BR_OFF_W (BR_OFF_W),
    .JMP_OFF_W(JMP_OFF_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pcIn     (pcIn),
    .brOffset (brOffset),
    .jmpOffset(jmpOffset),
    .nextPc   (nextPc),
    .cyclesOut(cyclesOut),
    .resValid (resValid)
  );

  // R1: an untaken branch steps by one word
  a_r1_untaken_step: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opKind == 3'd1 && status[bitSel] != polarity)
      |=> (nextPc == $past(pcIn) + PC_W'(1)));
  // R2: a taken branch costs two cycles
  a_r2_taken_cycles: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opKind == 3'd1 && status[bitSel] == polarity)
      |=> (cyclesOut == 2'd2));
  // R6: a skip over a long instruction advances three words
  a_r6_long_skip: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opKind == 3'd4 && skipCond && nextIsLong)
      |=> (nextPc == $past(pcIn) + PC_W'(3) && cyclesOut == 2'd3));
  // R7: a failed skip is a plain step
  a_r7_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opKind == 3'd4 && !skipCond)
      |=> (nextPc == $past(pcIn) + PC_W'(1) && cyclesOut == 2'd1));
  // R10: no result pulse without a strobe
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !resValid);
endmodule

// File: tb/flow_resolver_test.sv
module flow_resolver_test;
  localparam int PC_W = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [2:0]  opKind;
  logic [15:0] pcIn;
  logic [6:0]  brOffset;
  logic [11:0] jmpOffset;
  logic [7:0]  status;
  logic [2:0]  bitSel;
  logic        polarity;
  logic        skipCond;
  logic        nextIsLong;
  logic [15:0] nextPc;
  logic [1:0]  cyclesOut;
  logic        resValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flow_resolver uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opKind(opKind),
    .pcIn(pcIn), .brOffset(brOffset), .jmpOffset(jmpOffset),
    .status(status), .bitSel(bitSel), .polarity(polarity),
    .skipCond(skipCond), .nextIsLong(nextIsLong),
    .nextPc(nextPc), .cyclesOut(cyclesOut), .resValid(resValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    instValid = 0; opKind = 0; pcIn = 0; brOffset = 0; jmpOffset = 0;
    status = 0; bitSel = 0; polarity = 0; skipCond = 0; nextIsLong = 0;
  endtask

  // Drive on a falling edge, result is registered at the next rising edge,
  // sampled at the falling edge after it.
  task automatic issue(input logic [2:0] op, input logic [15:0] pc,
                       input logic [6:0] bo, input logic [11:0] jo,
                       input logic [7:0] st, input logic [2:0] bs, input logic pol,
                       input logic sk, input logic lng);
    @(negedge clk);
    instValid = 1; opKind = op; pcIn = pc; brOffset = bo; jmpOffset = jo;
    status = st; bitSel = bs; polarity = pol; skipCond = sk; nextIsLong = lng;
    @(negedge clk);
    instValid = 0;
  endtask

  task automatic expectRes(input string req, input logic [15:0] pc, input logic [1:0] cyc);
    check({req, " pc"}, 32'(nextPc), 32'(pc));
    check({req, " cycles"}, 32'(cyclesOut), 32'(cyc));
    check({req, " valid"}, 32'(resValid), 32'd1);
  endtask

  task automatic testReset();
    check("R11 pc", 32'(nextPc), 0);
    check("R11 cycles", 32'(cyclesOut), 0);
    check("R11 valid", 32'(resValid), 0);
  endtask

  task automatic testBranch();
    // R1 R2: forward taken, Z (bit 1) set, branch-if-set
    issue(3'd1, 16'h0100, 7'd5, 0, 8'h02, 3'd1, 1'b1, 0, 0);
    expectRes("R1 taken fwd", 16'h0106, 2'd2);
    // R1: backward taken, k = -4
    issue(3'd1, 16'h0100, 7'h7C, 0, 8'h00, 3'd0, 1'b0, 0, 0);
    expectRes("R1 taken back", 16'h00FD, 2'd2);
    // R1 R2: not taken
    issue(3'd1, 16'h0200, 7'd20, 0, 8'h00, 3'd1, 1'b1, 0, 0);
    expectRes("R2 not taken", 16'h0201, 2'd1);
    // R1: most negative offset -64
    issue(3'd1, 16'h1000, 7'h40, 0, 8'h10, 3'd4, 1'b1, 0, 0);
    expectRes("R1 min offset", 16'h0FC1, 2'd2);
  endtask

  task automatic testBitSelect();
    // R3: every bit, both polarities, a single bit set
    for (int b = 0; b < 8; b++) begin
      issue(3'd1, 16'h0300, 7'd10, 0, 8'(1 << b), 3'(b), 1'b1, 0, 0);
      expectRes("R3 set hit", 16'h030B, 2'd2);
      issue(3'd1, 16'h0300, 7'd10, 0, 8'(1 << b), 3'(b), 1'b0, 0, 0);
      expectRes("R3 clear miss", 16'h0301, 2'd1);
      issue(3'd1, 16'h0300, 7'd10, 0, ~8'(1 << b), 3'(b), 1'b1, 0, 0);
      expectRes("R3 set miss", 16'h0301, 2'd1);
      issue(3'd1, 16'h0300, 7'd10, 0, ~8'(1 << b), 3'(b), 1'b0, 0, 0);
      expectRes("R3 clear hit", 16'h030B, 2'd2);
    end
  endtask

  task automatic testJumpCall();
    issue(3'd2, 16'h0400, 0, 12'd100, 8'h00, 0, 0, 0, 0);
    expectRes("R4 jump fwd", 16'h0465, 2'd2);
    issue(3'd2, 16'h0400, 0, 12'h800, 8'h00, 0, 0, 0, 0);
    expectRes("R4 jump min", 16'hFC01, 2'd2);
    issue(3'd3, 16'h0400, 0, 12'hFFE, 8'h00, 0, 0, 0, 0);
    expectRes("R5 call back", 16'h03FF, 2'd3);
  endtask

  task automatic testSkip();
    issue(3'd4, 16'h0500, 7'd30, 12'd30, 8'hFF, 0, 1, 1'b1, 1'b0);
    expectRes("R6 skip short", 16'h0502, 2'd2);
    issue(3'd4, 16'h0500, 0, 0, 8'h00, 0, 0, 1'b1, 1'b1);
    expectRes("R6 skip long", 16'h0503, 2'd3);
    issue(3'd4, 16'h0500, 0, 0, 8'h00, 0, 0, 1'b0, 1'b1);
    expectRes("R7 no skip long", 16'h0501, 2'd1);
    issue(3'd4, 16'h0500, 0, 0, 8'h00, 0, 0, 1'b0, 1'b0);
    expectRes("R7 no skip short", 16'h0501, 2'd1);
  endtask

  task automatic testPlain();
    issue(3'd0, 16'h0600, 7'd9, 12'd9, 8'hFF, 3'd7, 1'b1, 1'b1, 1'b1);
    expectRes("R8 plain", 16'h0601, 2'd1);
    issue(3'd6, 16'h0700, 7'd9, 12'd9, 8'hFF, 3'd7, 1'b1, 1'b1, 1'b1);
    expectRes("R8 unused code", 16'h0701, 2'd1);
  endtask

  task automatic testWrap();
    issue(3'd4, 16'hFFFE, 0, 0, 0, 0, 0, 1'b1, 1'b1);
    expectRes("R9 wrap skip", 16'h0001, 2'd3);
    issue(3'd1, 16'h0002, 7'h7C, 0, 8'h01, 3'd0, 1'b1, 0, 0);
    expectRes("R9 wrap back", 16'hFFFF, 2'd2);
    issue(3'd2, 16'hFFF0, 0, 12'd20, 0, 0, 0, 0, 0);
    expectRes("R9 wrap jump", 16'h0005, 2'd2);
  endtask

  task automatic testHold();
    issue(3'd2, 16'h0800, 0, 12'd15, 0, 0, 0, 0, 0);
    expectRes("R10 load", 16'h0810, 2'd2);
    // strobe low, inputs scrambled: outputs must not move
    opKind = 3'd3; pcIn = 16'hABCD; jmpOffset = 12'h123; skipCond = 1;
    @(negedge clk);
    check("R10 hold pc", 32'(nextPc), 32'h0810);
    check("R10 hold cycles", 32'(cyclesOut), 2);
    check("R10 valid drops", 32'(resValid), 0);
    @(negedge clk);
    check("R10 still held", 32'(nextPc), 32'h0810);
  endtask

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    testBranch();
    testBitSelect();
    testJumpCall();
    testSkip();
    testPlain();
    testWrap();
    testHold();
    // R11: reset clears outputs after activity
    rstN = 0;
    @(negedge clk);
    testReset();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule